// File: doc/BRIEF.md
# Mailbox FIFO with register read port

This block is the receive-side mailbox of a link endpoint. Messages of 64 bits arrive on a plain valid/data push input and are queued in a power-of-two deep FIFO. A host drains the queue through a 32-bit configuration read port. Each message is read as two halves: the low half at one address, then the high half at a second address.

Reading the high half is what removes the message. No separate pop strobe exists. The low half can be read as often as needed without disturbing the queue. A not-empty level is meant to drive an interrupt line. A full flag and a sticky overflow flag report the queue's capacity state.

Readback data is registered. Each read result appears on the readback bus one clock after the read request.

Top module: `mbox_fifo`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `not_empty`, `full` and `overflow` are 0 and `cfg_rdata` is 0.
- R2: A push (`push_valid` high while not full) stores `push_data` in the queue. Messages leave the queue in the order they arrived.
- R3: A read (`cfg_en`=1, `cfg_we`=0) at address `LO_ADDR` returns bits [31:0] of the oldest message on `cfg_rdata` after the next clock edge. The read does not remove the message, so repeated reads return the same value.
- R4: A read at address `HI_ADDR` returns bits [63:32] of the oldest message after the next clock edge, and removes exactly that message.
- R5: A read of either half while the queue is empty returns 0 and leaves the queue unchanged.
- R6: `not_empty` is 1 exactly when at least one message is stored. It follows each push or removal at the same clock edge that performs it.
- R7: `full` is 1 exactly when `DEPTH` messages are stored.
- R8: A push while `full` is 1 is dropped, even when a removal occurs in the same cycle. Such a push sets `overflow`, which stays 1 until reset.
- R9: A push and a high-half read in the same cycle, with the queue neither empty nor full, keep the stored count unchanged. Both actions take effect.
- R10: A cycle with `cfg_en`=0 or `cfg_we`=1 changes neither the queue nor `cfg_rdata`. A read at any address other than `LO_ADDR` or `HI_ADDR` returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push request for an incoming message |
| push_data | input | 64 | Incoming message |
| cfg_en | input | 1 | Configuration access enable |
| cfg_we | input | 1 | Configuration write (a read when low) |
| cfg_addr | input | AW (20) | Configuration register address |
| cfg_rdata | output | 32 | Registered readback data |
| not_empty | output | 1 | At least one message is held (interrupt level) |
| full | output | 1 | Queue cannot accept another message |
| overflow | output | 1 | Sticky: a push was dropped while full |

## Verification
A wrong pointer or a corrupted storage slot does not stay hidden. It shows on `cfg_rdata` one clock after the next read of that message: either the wrong half, stale data, or messages out of arrival order. An occupancy error shows on `not_empty` or `full` at the very edge where the count crosses zero or `DEPTH`. A pop triggered by a low-half read, a write, or an unmapped address shows one read later, as the next message appearing too early. The bench walks every fill level of a small queue and compares the ports against an arithmetic model each cycle, so each of these faults surfaces within one message of its cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // One queued message, split into the two host-visible halves.
    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } mbox_entry_t;

    // Which half of the head message a register access targets.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } mbox_sel_e;

    // Value returned for a given half selection; zero when nothing is held.
    function automatic logic [31:0] mbox_half(input mbox_entry_t ent,
                                              input mbox_sel_e   sel,
                                              input logic        is_empty);
        logic [31:0] res;
        res = '0;
        if (!is_empty) begin
            unique case (sel)
                SEL_LO:  res = ent.lo;
                SEL_HI:  res = ent.hi;
                default: res = '0;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/mbox_ptrs.sv
module mbox_ptrs #(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push_req,
    input  logic                      pop_req,
    output logic [$clog2(DEPTH)-1:0]  wr_idx,
    output logic [$clog2(DEPTH)-1:0]  rd_idx,
    output logic [$clog2(DEPTH):0]    rd_ptr_o,
    output logic                      wr_en,
    output logic                      empty,
    output logic                      full,
    output logic                      overflow
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          pop_ok;
    logic          ovf_q;

    // Extra pointer bit distinguishes a full queue from an empty one.
    assign empty  = (wr_ptr == rd_ptr);
    assign full   = (wr_ptr[IW] != rd_ptr[IW]) && (wr_ptr[IW-1:0] == rd_ptr[IW-1:0]);
    assign wr_en  = push_req && !full;
    assign pop_ok = pop_req && !empty;

    assign wr_idx   = wr_ptr[IW-1:0];
    assign rd_idx   = rd_ptr[IW-1:0];
    assign rd_ptr_o = rd_ptr;
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_en)           wr_ptr <= wr_ptr + PW'(1);
            if (pop_ok)          rd_ptr <= rd_ptr + PW'(1);
            if (push_req && full) ovf_q <= 1'b1;
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> (wr_ptr == $past(wr_ptr)));                          // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                                      // R8
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> (rd_ptr == $past(rd_ptr)));                           // R5
    AST_RD_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == $past(rd_ptr) + PW'(1)));           // R4
    AST_BOTH_KEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !full && !empty)
            |=> ((wr_ptr - rd_ptr) == $past(wr_ptr - rd_ptr)));                      // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));                                                           // R7

endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  mbox_entry_t               wr_data,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    output mbox_entry_t               rd_data
);
    mbox_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int             AW      = 20,
    parameter logic [AW-1:0]  LO_ADDR = 20'h00040,
    parameter logic [AW-1:0]  HI_ADDR = 20'h00048
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  mbox_entry_t   head,
    input  logic          empty,
    output logic          pop_req,
    output logic [31:0]   rdata
);
    logic      rd_strobe;
    mbox_sel_e sel;

    assign rd_strobe = cfg_en && !cfg_we;

    always_comb begin
        sel = SEL_NONE;
        if (rd_strobe) begin
            if (cfg_addr == LO_ADDR)      sel = SEL_LO;
            else if (cfg_addr == HI_ADDR) sel = SEL_HI;
        end
    end

    // Reading the high half is the pop; the pointer block ignores it when empty.
    assign pop_req = (sel == SEL_HI);

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (rd_strobe) rdata <= mbox_half(head, sel, empty);
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rdata));                                              // R10
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && empty) |=> (rdata == 32'd0));                                  // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && cfg_addr != LO_ADDR && cfg_addr != HI_ADDR) |=> (rdata == 32'd0)); // R10

endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int             DEPTH   = 16,
    parameter int             AW      = 20,
    parameter logic [AW-1:0]  LO_ADDR = 20'h00040,
    parameter logic [AW-1:0]  HI_ADDR = 20'h00048
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [63:0]   push_data,
    input  logic          cfg_en,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    output logic [31:0]   cfg_rdata,
    output logic          not_empty,
    output logic          full,
    output logic          overflow
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;
    logic [IW:0]   rd_ptr;
    logic          wr_en;
    logic          empty;
    logic          pop_req;
    mbox_entry_t   head;
    mbox_entry_t   in_ent;

    initial begin
        if (DEPTH < 2 || (1 << IW) != DEPTH)
            $error("mbox_fifo: DEPTH must be a power of two of at least 2");
    end

    assign in_ent = '{hi: push_data[63:32], lo: push_data[31:0]};

    mbox_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .rd_ptr_o (rd_ptr),
        .wr_en    (wr_en),
        .empty    (empty),
        .full     (full),
        .overflow (overflow)
    );

    mbox_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_ent),
        .rd_idx  (rd_idx),
        .rd_data (head)
    );

    mbox_regif #(.AW(AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .head     (head),
        .empty    (empty),
        .pop_req  (pop_req),
        .rdata    (cfg_rdata)
    );

    assign not_empty = !empty;

    AST_LO_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_we && cfg_addr == LO_ADDR) |=> (rd_ptr == $past(rd_ptr)));   // R3
    AST_WRITE_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_we) |=> (rd_ptr == $past(rd_ptr)));                           // R10
    AST_NE_RISE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(not_empty) |-> $past(push_valid));                                     // R6
    AST_FULL_RISE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(push_valid));                                          // R7

endmodule

// File: tb/sim_mbox_fifo.sv
`timescale 1ns/1ps
module sim_mbox_fifo;
    localparam int D = 4;
    localparam logic [19:0] A_LO = 20'h00040;
    localparam logic [19:0] A_HI = 20'h00048;
    localparam logic [19:0] A_XX = 20'h00044;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid;
    logic [63:0] push_data;
    logic        cfg_en;
    logic        cfg_we;
    logic [19:0] cfg_addr;
    logic [31:0] cfg_rdata;
    logic        not_empty;
    logic        full;
    logic        overflow;

    int errors = 0;
    int checks = 0;
    int seq    = 0;

    logic [63:0] mq [D];
    int          mh, mc;
    logic        m_ovf;
    logic [31:0] m_rd;

    always #5 clk = ~clk;

    mbox_fifo #(.DEPTH(D), .AW(20), .LO_ADDR(A_LO), .HI_ADDR(A_HI)) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_rdata(cfg_rdata), .not_empty(not_empty), .full(full), .overflow(overflow)
    );

    function automatic logic [63:0] msg(input int i);
        return {32'hC0DE_0000 | 32'(i), ~32'(i * 7 + 3)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, 64'(cfg_rdata), 64'(m_rd));
        chk("R6 not_empty", 64'(not_empty), 64'(mc > 0));
        chk("R7 full", 64'(full), 64'(mc == D));
        chk("R8 overflow", 64'(overflow), 64'(m_ovf));
    endtask

    // One clock with the given inputs; model updated, then ports compared.
    task automatic cyc(input logic pv, input logic [63:0] pd, input logic en,
                       input logic we, input logic [19:0] a, input string tag);
        logic do_push, do_pop;
        push_valid = pv; push_data = pd; cfg_en = en; cfg_we = we; cfg_addr = a;
        do_push = pv && (mc < D);
        do_pop  = en && !we && (a == A_HI) && (mc > 0);
        if (pv && mc == D) m_ovf = 1'b1;
        if (en && !we) begin
            if (mc == 0)        m_rd = 32'd0;
            else if (a == A_LO) m_rd = mq[mh][31:0];
            else if (a == A_HI) m_rd = mq[mh][63:32];
            else                m_rd = 32'd0;
        end
        if (do_push) mq[(mh + mc) % D] = pd;
        if (do_pop) begin mh = (mh + 1) % D; mc = mc - 1; end
        if (do_push) mc = mc + 1;
        @(posedge clk); #1;
        push_valid = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0;
        chk_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; push_valid = 1'b0; push_data = '0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 rdata in reset", 64'(cfg_rdata), 64'd0);
        chk("R1 not_empty in reset", 64'(not_empty), 64'd0);
        rst = 1'b0;
        mh = 0; mc = 0; m_ovf = 1'b0; m_rd = '0;
        @(posedge clk); #1;
        chk_all("R1 after reset");
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, msg(seq), 1'b0, 1'b0, A_LO, "R2 push");
            seq++;
        end
    endtask

    task automatic drain();
        while (mc > 0) begin
            cyc(1'b0, '0, 1'b1, 1'b0, A_LO, "R3 low half");
            cyc(1'b0, '0, 1'b1, 1'b0, A_HI, "R4 high half pop");
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // Empty reads
        cyc(1'b0, '0, 1'b1, 1'b0, A_LO, "R5 low read empty");
        cyc(1'b0, '0, 1'b1, 1'b0, A_HI, "R5 high read empty");
        // Repeated low reads do not pop
        push_n(1);
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, 1'b0, A_LO, "R3 repeat low");
        cyc(1'b0, '0, 1'b1, 1'b0, A_HI, "R4 pop");
        cyc(1'b0, '0, 1'b1, 1'b0, A_HI, "R5 high after drain");
        // Writes, idle, unmapped: no pop, readback behaviour
        push_n(2);
        cyc(1'b0, '0, 1'b1, 1'b0, A_LO, "R3 low");
        cyc(1'b0, '0, 1'b1, 1'b1, A_HI, "R10 write to high");
        cyc(1'b0, '0, 1'b0, 1'b0, A_HI, "R10 disabled high");
        cyc(1'b0, '0, 1'b1, 1'b0, A_XX, "R10 unmapped");
        drain();
        // Sweep every fill level with push only, push+pop, and overflow at full
        for (int n = 0; n <= D; n++) begin
            do_reset();
            push_n(n);
            cyc(1'b1, msg(seq), 1'b1, 1'b0, A_HI, (n == D) ? "R8 push+pop at full" : "R9 push+pop");
            seq++;
            if (n == D) begin
                push_n(1);
                cyc(1'b1, msg(seq), 1'b0, 1'b0, A_LO, "R8 push at full");
                seq++;
            end
            drain();
        end
        // Overflow sticky through drain, cleared by reset
        push_n(D + 2);
        drain();
        cyc(1'b0, '0, 1'b1, 1'b0, A_LO, "R8 sticky after drain");
        do_reset();
        // Wrap the pointers several times in order
        for (int r = 0; r < 3 * D; r++) begin
            push_n(1 + (r % D));
            drain();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule